// File: doc/BRIEF.md
# Serial Flash Chip-Erase Sequencer

This block is the host side of a full-device erase on an SPI serial flash. One pulse on `start_i` runs the whole erase. The block first sends a write-enable frame, then a frame with the chip-erase opcode. It then waits for the flash to finish, in one of two ways. It can hold chip enable low and read a status byte over and over until the busy flag drops. Or it can simply count a fixed number of clocks. Success gives a one-cycle `done_o` pulse. A poll that stays busy for too long sets a sticky `err_o`.

The serial clock uses SPI mode 0: it idles low, and bits go out most significant first. Each half period of SCK lasts `SCK_DIV` system clocks. Chip enable stays high for at least `CS_GAP` clocks between frames. The fixed erase wait is `ERASE_CYC` clocks. The wait mode and the timeout limit are captured when a sequence starts, so later changes to those inputs do not affect a sequence already running.

Top module: `flash_erase_ctrl`

## Requirements
- R1: SCK is low whenever chip enable is high and at the start of every frame. MOSI changes only while SCK is low. Bits go out most significant first, and each SCK level lasts exactly `SCK_DIV` clocks.
- R2: A start pulse in idle lowers chip enable and sends one byte, 0x06, as 8 SCK pulses. Chip enable rises one clock after the last falling SCK edge.
- R3: The second frame carries only the byte 0x60. Chip enable rises one clock after its last falling SCK edge.
- R4: Between any two frames, chip enable stays high for exactly `CS_GAP` clocks, and never fewer.
- R5: In poll mode (`fixed_wait_i` = 0 at start), the third frame sends 0x05 and then keeps clocking out 0x00 filler bytes with chip enable still low. There is one SCK-low clock between bytes. The busy flag is the last bit received in each status byte, which is status bit 0; 1 means busy.
- R6: After the first status byte whose busy bit is 0, chip enable rises and `done_o` is high for exactly that one clock. `done_o` and chip enable low never occur together.
- R7: If `tmo_limit_i` consecutive status bytes report busy, chip enable rises, `err_o` is set, and the block goes idle. A limit of 0 acts as 1. `err_o` stays set until the next accepted start and is never high together with `done_o`.
- R8: In fixed mode (`fixed_wait_i` = 1 at start), no third frame is sent. `done_o` is high for one clock, exactly `CS_GAP`+`ERASE_CYC` clocks after the first clock with chip enable high that follows the erase frame.
- R9: `start_i` has no effect while a sequence is running.
- R10: During and after reset, chip enable is high and `sck_o`, `mosi_o`, `done_o` and `err_o` are low.
- R11: `fixed_wait_i` and `tmo_limit_i` are captured at start. Later changes to them do not alter the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begins an erase sequence when idle |
| fixed_wait_i | input | 1 | 1 selects the fixed wait, 0 selects status polling |
| tmo_limit_i | input | TMO_W | Number of busy status bytes that counts as a timeout |
| miso_i | input | 1 | Serial data from the flash |
| sck_o | output | 1 | Serial clock, mode 0 |
| cs_n_o | output | 1 | Active-low chip enable |
| mosi_o | output | 1 | Serial data to the flash |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | Sticky poll-timeout flag |

## Verification
The bench builds the block with `SCK_DIV`=2, `CS_GAP`=3, `ERASE_CYC`=50 and `TMO_W`=4. With these values a frame byte takes 33 clocks and the fixed wait is short, so every SCK edge, gap and status byte is compared clock by clock. The 4-bit limit puts the timeout boundaries within a few status bytes: the limit reached exactly, the limit missed by one, and a limit of zero. It also leaves room to change the latched inputs and re-pulse start in the middle of a sequence.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREN,
    ST_GAP_A,
    ST_ERASE,
    ST_GAP_B,
    ST_WAIT,
    ST_POLL_OP,
    ST_POLL_RD
  } seq_state_e;

  localparam logic [7:0] OP_WR_EN      = 8'h06;
  localparam logic [7:0] OP_CHIP_ERASE = 8'h60;
  localparam logic [7:0] OP_RD_STATUS  = 8'h05;
  localparam logic [7:0] FILL_BYTE     = 8'h00;

endpackage

// File: rtl/fe_reset_sync.sv
module fe_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync_o = sync_q[1];

endmodule

// File: rtl/fe_spi_shifter.sv
module fe_spi_shifter #(
  parameter int SCK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       last_bit_o,
  output logic       done_o
);

  localparam int DW = $clog2(SCK_DIV + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(SCK_DIV - 1);

  logic [DW-1:0] div_q, div_n;
  logic [7:0]    sh_q, sh_n;
  logic [2:0]    bit_q, bit_n;
  logic          sck_q, sck_n;
  logic          act_q, act_n;
  logic          last_q, last_n;
  logic          done_q, done_n;

  always_comb begin
    div_n  = div_q;
    sh_n   = sh_q;
    bit_n  = bit_q;
    sck_n  = sck_q;
    act_n  = act_q;
    last_n = last_q;
    done_n = 1'b0;
    if (load_i) begin
      div_n = '0;
      sh_n  = byte_i;
      bit_n = 3'd0;
      sck_n = 1'b0;
      act_n = 1'b1;
    end else if (act_q) begin
      if (div_q == DIV_LAST) begin
        div_n = '0;
        if (!sck_q) begin
          // rising edge: capture the incoming bit
          sck_n  = 1'b1;
          last_n = miso_i;
        end else begin
          // falling edge: present the next outgoing bit
          sck_n = 1'b0;
          sh_n  = {sh_q[6:0], 1'b0};
          if (bit_q == 3'd7) begin
            act_n  = 1'b0;
            done_n = 1'b1;
          end else begin
            bit_n = bit_q + 3'd1;
          end
        end
      end else begin
        div_n = div_q + DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sh_q   <= 8'h00;
      bit_q  <= 3'd0;
      sck_q  <= 1'b0;
      act_q  <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      div_q  <= div_n;
      sh_q   <= sh_n;
      bit_q  <= bit_n;
      sck_q  <= sck_n;
      act_q  <= act_n;
      last_q <= last_n;
      done_q <= done_n;
    end
  end

  assign sck_o      = sck_q;
  assign mosi_o     = sh_q[7];
  assign last_bit_o = last_q;
  assign done_o     = done_q;

endmodule

// File: rtl/fe_sequencer.sv
module fe_sequencer
  import flash_erase_pkg::*;
#(
  parameter int CS_GAP    = 2,
  parameter int ERASE_CYC = 1000,
  parameter int TMO_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             fixed_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic             byte_done_i,
  input  logic             busy_bit_i,
  output logic             load_o,
  output logic [7:0]       byte_o,
  output logic             cs_n_o,
  output logic             done_o,
  output logic             err_o
);

  localparam int TMAX = (CS_GAP > ERASE_CYC) ? CS_GAP : ERASE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] GAP_LAST  = TW'(CS_GAP - 1);
  localparam logic [TW-1:0] WAIT_LAST = TW'(ERASE_CYC - 1);

  seq_state_e       st_q, st_n;
  logic [TW-1:0]    tick_q, tick_n;
  logic [TMO_W-1:0] poll_q, poll_n;
  logic [TMO_W-1:0] tmo_q, tmo_n;
  logic             fixed_q, fixed_n;
  logic             cs_n_q, cs_n_n;
  logic             done_q, done_n;
  logic             err_q, err_n;
  logic [TMO_W:0]   poll_inc;

  assign poll_inc = {1'b0, poll_q} + {{TMO_W{1'b0}}, 1'b1};

  always_comb begin
    st_n    = st_q;
    tick_n  = tick_q;
    poll_n  = poll_q;
    tmo_n   = tmo_q;
    fixed_n = fixed_q;
    cs_n_n  = cs_n_q;
    err_n   = err_q;
    done_n  = 1'b0;
    load_o  = 1'b0;
    byte_o  = FILL_BYTE;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          fixed_n = fixed_i;
          tmo_n   = tmo_i;
          err_n   = 1'b0;
          cs_n_n  = 1'b0;
          load_o  = 1'b1;
          byte_o  = OP_WR_EN;
          st_n    = ST_WREN;
        end
      end
      ST_WREN: begin
        if (byte_done_i) begin
          cs_n_n = 1'b1;
          tick_n = '0;
          st_n   = ST_GAP_A;
        end
      end
      ST_GAP_A: begin
        if (tick_q == GAP_LAST) begin
          cs_n_n = 1'b0;
          load_o = 1'b1;
          byte_o = OP_CHIP_ERASE;
          st_n   = ST_ERASE;
        end else begin
          tick_n = tick_q + TW'(1);
        end
      end
      ST_ERASE: begin
        if (byte_done_i) begin
          cs_n_n = 1'b1;
          tick_n = '0;
          st_n   = ST_GAP_B;
        end
      end
      ST_GAP_B: begin
        if (tick_q == GAP_LAST) begin
          tick_n = '0;
          if (fixed_q) begin
            st_n = ST_WAIT;
          end else begin
            cs_n_n = 1'b0;
            load_o = 1'b1;
            byte_o = OP_RD_STATUS;
            st_n   = ST_POLL_OP;
          end
        end else begin
          tick_n = tick_q + TW'(1);
        end
      end
      ST_WAIT: begin
        if (tick_q == WAIT_LAST) begin
          done_n = 1'b1;
          st_n   = ST_IDLE;
        end else begin
          tick_n = tick_q + TW'(1);
        end
      end
      ST_POLL_OP: begin
        if (byte_done_i) begin
          poll_n = '0;
          load_o = 1'b1;
          st_n   = ST_POLL_RD;
        end
      end
      ST_POLL_RD: begin
        if (byte_done_i) begin
          if (!busy_bit_i) begin
            cs_n_n = 1'b1;
            done_n = 1'b1;
            st_n   = ST_IDLE;
          end else if (poll_inc >= {1'b0, tmo_q}) begin
            cs_n_n = 1'b1;
            err_n  = 1'b1;
            st_n   = ST_IDLE;
          end else begin
            poll_n = poll_inc[TMO_W-1:0];
            load_o = 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tick_q  <= '0;
      poll_q  <= '0;
      tmo_q   <= '0;
      fixed_q <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      tick_q  <= tick_n;
      poll_q  <= poll_n;
      tmo_q   <= tmo_n;
      fixed_q <= fixed_n;
      cs_n_q  <= cs_n_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  assign cs_n_o = cs_n_q;
  assign done_o = done_q;
  assign err_o  = err_q;

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl #(
  parameter int SCK_DIV   = 4,
  parameter int CS_GAP    = 2,
  parameter int ERASE_CYC = 100000,
  parameter int TMO_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             fixed_wait_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  input  logic             miso_i,
  output logic             sck_o,
  output logic             cs_n_o,
  output logic             mosi_o,
  output logic             done_o,
  output logic             err_o
);

  logic       rst_n_int;
  logic       load;
  logic [7:0] tx_byte;
  logic       byte_done;
  logic       last_bit;

  fe_reset_sync rst_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  fe_spi_shifter #(
    .SCK_DIV (SCK_DIV)
  ) shift_i (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .load_i     (load),
    .byte_i     (tx_byte),
    .miso_i     (miso_i),
    .sck_o      (sck_o),
    .mosi_o     (mosi_o),
    .last_bit_o (last_bit),
    .done_o     (byte_done)
  );

  fe_sequencer #(
    .CS_GAP    (CS_GAP),
    .ERASE_CYC (ERASE_CYC),
    .TMO_W     (TMO_W)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start_i     (start_i),
    .fixed_i     (fixed_wait_i),
    .tmo_i       (tmo_limit_i),
    .byte_done_i (byte_done),
    .busy_bit_i  (last_bit),
    .load_o      (load),
    .byte_o      (tx_byte),
    .cs_n_o      (cs_n_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

endmodule

// File: rtl/flash_erase_ctrl_chk.sv
module flash_erase_ctrl_chk #(
  parameter int CS_GAP = 2
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic sck_o,
  input logic cs_n_o,
  input logic mosi_o,
  input logic done_o,
  input logic err_o
);

  localparam int HW = $clog2(CS_GAP + 2);
  localparam logic [HW-1:0] HMAX = HW'(CS_GAP);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= HMAX;
    end else if (!cs_n_o) begin
      hi_cnt <= '0;
    end else if (hi_cnt != HMAX) begin
      hi_cnt <= hi_cnt + HW'(1);
    end
  end

  // R1
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sck_o);

  // R1
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi_o) |-> !sck_o);

  // R4
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (hi_cnt == HMAX));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  done_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cs_n_o);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> err_o);

  // R7
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

endmodule

bind flash_erase_ctrl flash_erase_ctrl_chk #(.CS_GAP(CS_GAP)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .sck_o   (sck_o),
  .cs_n_o  (cs_n_o),
  .mosi_o  (mosi_o),
  .done_o  (done_o),
  .err_o   (err_o)
);

// File: tb/flash_erase_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_erase_ctrl_tb_top;

  localparam int DIV  = 2;
  localparam int GAP  = 3;
  localparam int WAIT = 50;
  localparam int TW   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          fixed_i = 1'b0;
  logic [TW-1:0] tmo_i = '0;
  logic          miso;
  logic          sck, cs_n, mosi, done, err;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  int rise_cnt = 0;
  int busy_rises = 0;
  logic prev_sck = 1'b0;

  logic [4:0] exp_q[$];
  int         tag_q[$];

  always #2 clk = ~clk;

  flash_erase_ctrl #(
    .SCK_DIV   (DIV),
    .CS_GAP    (GAP),
    .ERASE_CYC (WAIT),
    .TMO_W     (TW)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .fixed_wait_i (fixed_i),
    .tmo_limit_i  (tmo_i),
    .miso_i       (miso),
    .sck_o        (sck),
    .cs_n_o       (cs_n),
    .mosi_o       (mosi),
    .done_o       (done),
    .err_o        (err)
  );

  // Flash model: answers busy (all ones) until the chosen number of
  // status bytes has gone by, counting SCK rises within the frame.
  assign miso = (rise_cnt < busy_rises);

  always @(negedge clk) begin
    if (cs_n) rise_cnt <= 0;
    else if (sck && !prev_sck) rise_cnt <= rise_cnt + 1;
    prev_sck <= sck;
  end

  task automatic check(input logic [4:0] got, input logic [4:0] exp, input int tag, input int cyc);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d cycle %0d: got cs,sck,mosi,done,err=%b expected %b", tag, cyc, got, exp);
    end
  endtask

  task automatic push(input bit c, input bit s, input bit m, input bit d, input bit e, input int tag);
    exp_q.push_back({c, s, m, d, e});
    tag_q.push_back(tag);
  endtask

  // One byte within a frame: SCK_DIV clocks per level, MSB first (R1)
  task automatic push_byte(input logic [7:0] b, input int tag);
    for (int t = 0; t <= 16 * DIV; t++) begin
      int ph = t / DIV;
      int ix = ph / 2;
      push(1'b0, ph[0], (ix < 8) ? b[7 - ix] : 1'b0, 1'b0, 1'b0, tag);
    end
  endtask

  task automatic push_idle(input int n, input bit e, input int tag);
    for (int k = 0; k < n; k++) push(1'b1, 1'b0, 1'b0, 1'b0, e, tag);
  endtask

  task automatic run_case(input bit fx, input int tmo, input int nbusy, input bit disturb);
    int teff;
    int nbytes;
    bit fail_end;
    exp_q.delete();
    tag_q.delete();
    teff = (tmo == 0) ? 1 : tmo;
    busy_rises = 8 + 8 * nbusy;
    push_byte(8'h06, 2);            // R2 write-enable frame
    push_idle(GAP, 1'b0, 4);        // R4 gap
    push_byte(8'h60, 3);            // R3 chip-erase frame
    push_idle(GAP, 1'b0, 4);        // R4 gap
    fail_end = 1'b0;
    if (fx) begin
      push_idle(WAIT, 1'b0, 8);     // R8 fixed wait
      push(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8);
    end else begin
      push_byte(8'h05, 5);          // R5 status opcode
      if (nbusy < teff) nbytes = nbusy + 1;
      else begin nbytes = teff; fail_end = 1'b1; end
      for (int j = 0; j < nbytes; j++) push_byte(8'h00, 5);
      if (fail_end) push(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 7);   // R7 timeout
      else push(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6);            // R6 done
    end
    push_idle(6, fail_end, fail_end ? 7 : 6);
    fixed_i = fx;
    tmo_i = TW'(tmo);
    @(negedge clk);
    start_i = 1'b1;
    for (int i = 0; i < exp_q.size(); i++) begin
      @(negedge clk);
      // R9: extra start pulses mid-sequence; R11: inputs change after start
      start_i = disturb && (i == 40 || i == 100);
      if (disturb && i == 10) begin
        fixed_i = ~fx;
        tmo_i = TW'(1);
      end
      check({cs_n, sck, mosi, done, err}, exp_q[i], tag_q[i], i);
    end
    start_i = 1'b0;
  endtask

  initial begin
    // R10 reset state
    repeat (3) begin
      @(negedge clk);
      check({cs_n, sck, mosi, done, err}, 5'b10000, 10, 0);
    end
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check({cs_n, sck, mosi, done, err}, 5'b10000, 10, 0);

    run_case(1'b0, 4, 0, 1'b0);   // R6 ready at first status byte
    run_case(1'b0, 8, 3, 1'b1);   // R5 R9 R11 several busy bytes, disturbed
    run_case(1'b0, 3, 5, 1'b0);   // R7 timeout after limit
    run_case(1'b0, 3, 2, 1'b0);   // R6 ready one byte before limit; clears err
    run_case(1'b0, 2, 2, 1'b0);   // R7 busy exactly at limit
    run_case(1'b0, 0, 4, 1'b0);   // R7 limit zero acts as one
    run_case(1'b1, 5, 0, 1'b0);   // R8 fixed wait, clears err
    run_case(1'b1, 5, 9, 1'b1);   // R8 R9 R11 fixed wait, disturbed

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R6 watchdog: got no completion expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule